// File: doc/BRIEF.md
# Serial Word-Memory Command Interface

This block is the slave side of a four-wire serial link in front of a 16-word by 16-bit RAM. The host raises a chip-enable, clocks bits in on a data-in line and gets read data back on a data-out line that has its own output enable. Every command opens with a start bit, which is a logic one. Any zeros clocked in before it are dropped. The start bit is followed by an 8-bit instruction that carries a word address and an opcode.

The write and read opcodes move 16-bit words between the serial link and the internal RAM. The other five opcodes do not move data. Each one raises a single-cycle request pulse towards a separate nonvolatile controller. The block samples the serial clock, chip-enable and data-in inside a faster system clock domain and works from the edges it detects there. The serial clock may stop at any point for any length of time. Two inputs come from outside: a write permission input gates RAM updates, and a busy input from the nonvolatile controller causes commands to be discarded.

Top module: `swm_serial_if`

## Requirements
- R1: While chip-enable is high and no command is open, bits of value 0 sampled on data-in are discarded. The first 1 sampled on a rising serial clock edge is taken as instruction bit 7.
- R2: Instructions are 8 bits, sent MSB first and sampled on rising serial clock edges. Bit 7 is 1, bits 6..3 are the word address and bits 2..0 are the opcode.
- R3: Opcodes 000, 001, 010, 100 and 101 each produce one pulse, one system clock long, on req_wrdis_o, req_store_o, req_autoen_o, req_wren_o and req_recall_o respectively. No other request output pulses.
- R4: Opcode 011 is a write. It is followed by 16 data bits, MSB first, and the word is written to the addressed RAM location when chip-enable falls.
- R5: If k data bits (1 to 15) have arrived when chip-enable falls, they are written into word bits 15 down to 16-k, and the remaining bits of the word keep their previous values. If k is 0, the word is unchanged.
- R6: If more than 16 data bits arrive, only the last 16 received are written.
- R7: Opcodes 110 and 111 are reads, so instruction bit 0 has no effect. Word bit 15 appears on sdo_o once the 8th serial clock falls. Each of rising edges 9 to 23 moves to the next lower bit. Output enable is high from the 8th falling edge until the 24th rising edge.
- R8: sdo_oe_o is low, and sdo_o is 0, at all times outside the read output window.
- R9: Chip-enable low ends any command in progress, forces sdo_oe_o low and returns the interface to waiting for a start bit.
- R10: If wr_allow_i is low when a write commits, the RAM word is left unchanged.
- R11: An instruction that completes while busy_i is high is discarded. It raises no request pulse, writes nothing and outputs no read data.
- R12: The serial clock may be held static for any time between edges with no loss of state. sdo_o changes only after a detected serial clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the serial pins |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_i | input | 1 | Chip-enable, active high |
| sck_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data in |
| busy_i | input | 1 | Nonvolatile controller busy; commands are discarded while it is high |
| wr_allow_i | input | 1 | Permission for RAM writes |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for sdo_o (pin is high impedance when low) |
| req_wrdis_o | output | 1 | Write-disable request pulse |
| req_store_o | output | 1 | Store request pulse |
| req_autoen_o | output | 1 | Autostore-enable request pulse |
| req_wren_o | output | 1 | Write-enable request pulse |
| req_recall_o | output | 1 | Recall request pulse |

## Verification
Some properties are checked by assertions on every cycle. The request outputs are at most one-hot and last one cycle, and none of them fires in the cycle after busy_i was high. Output enable drops once the synchronised chip-enable is low, it rises only after a detected falling serial edge, and sdo_o changes only after a detected serial edge. The other behaviours can only be shown by the bench's scenarios, which read the RAM back through the serial read path: the values stored by full, truncated and over-long writes, the start-bit search, the ignored read bit, the effect of wr_allow_i, and recovery after an aborted command.

// File: rtl/swm_pkg.sv
package swm_pkg;
  localparam int unsigned IR_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INSTR,
    ST_WDATA,
    ST_RDATA,
    ST_DONE
  } swm_state_e;

  localparam logic [2:0] OP_WRDIS  = 3'b000;
  localparam logic [2:0] OP_STORE  = 3'b001;
  localparam logic [2:0] OP_AUTOEN = 3'b010;
  localparam logic [2:0] OP_WRITE  = 3'b011;
  localparam logic [2:0] OP_WREN   = 3'b100;
  localparam logic [2:0] OP_RECALL = 3'b101;
endpackage

// File: rtl/swm_sync.sv
module swm_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[0] <= '0;
        else         stg_q[0] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[g] <= '0;
        else         stg_q[g] <= stg_q[g-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/swm_ram.sv
module swm_ram #(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[addr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/swm_serial_if.sv
module swm_serial_if
  import swm_pkg::*;
#(
  parameter int unsigned DW          = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_i,
  input  logic sck_i,
  input  logic sdi_i,
  input  logic busy_i,
  input  logic wr_allow_i,
  output logic sdo_o,
  output logic sdo_oe_o,
  output logic req_wrdis_o,
  output logic req_store_o,
  output logic req_autoen_o,
  output logic req_wren_o,
  output logic req_recall_o
);
  localparam int unsigned AW       = 4;
  localparam int unsigned KW       = $clog2(DW + 1);
  localparam int unsigned CW       = $clog2(IR_W + DW + 1);
  localparam logic [CW-1:0] RD_DEC   = CW'(IR_W - 2);
  localparam logic [CW-1:0] OP_DEC   = CW'(IR_W - 1);
  localparam logic [CW-1:0] RD_FIRST = CW'(IR_W);
  localparam logic [CW-1:0] RD_LAST  = CW'(IR_W + DW - 1);

  // pin sampling
  logic [2:0] syn;
  logic       ce_s, sck_s, sdi_s, ce_q, sck_q;
  logic       sck_rise, sck_fall, ce_fall;

  swm_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ce_i, sck_i, sdi_i}),
    .q_o   (syn)
  );
  assign {ce_s, sck_s, sdi_s} = syn;
  assign sck_rise = sck_s & ~sck_q;
  assign sck_fall = ~sck_s & sck_q;
  assign ce_fall  = ~ce_s & ce_q;

  swm_state_e    st_q;
  logic [CW-1:0] cnt_q;
  logic [5:0]    ir_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wsr_q, rsr_q;
  logic [KW-1:0] kcnt_q;
  logic          oe_q;
  logic [4:0]    req_q;
  logic [2:0]    op;

  logic          ram_we;
  logic [DW-1:0] ram_wdata, ram_rdata;
  logic [KW-1:0] shamt;
  logic [DW-1:0] ali, msk;

  assign op = {ir_q[1:0], sdi_s};

  // partial word: received bits left-aligned, rest from old word
  assign shamt     = KW'(DW) - kcnt_q;
  assign ali       = wsr_q << shamt;
  assign msk       = {DW{1'b1}} << shamt;
  assign ram_wdata = (ali & msk) | (ram_rdata & ~msk);
  assign ram_we    = ce_fall && (st_q == ST_WDATA) && (kcnt_q != '0) && wr_allow_i;

  swm_ram #(.DW(DW), .AW(AW)) u_ram (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (ram_we),
    .addr_i (addr_q),
    .wdata_i(ram_wdata),
    .rdata_o(ram_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q  <= 1'b0;
      ce_q   <= 1'b0;
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      ir_q   <= '0;
      addr_q <= '0;
      wsr_q  <= '0;
      rsr_q  <= '0;
      kcnt_q <= '0;
      oe_q   <= 1'b0;
      req_q  <= '0;
    end else begin
      sck_q <= sck_s;
      ce_q  <= ce_s;
      req_q <= '0;
      if (!ce_s) begin
        st_q   <= ST_IDLE;
        cnt_q  <= '0;
        ir_q   <= '0;
        kcnt_q <= '0;
        oe_q   <= 1'b0;
      end else begin
        unique case (st_q)
          ST_IDLE: if (sck_rise && sdi_s) begin
            ir_q  <= 6'b000001;
            cnt_q <= CW'(1);
            st_q  <= ST_INSTR;
          end
          ST_INSTR: if (sck_rise) begin
            ir_q  <= {ir_q[4:0], sdi_s};
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == RD_DEC && ir_q[0] && sdi_s) begin
              addr_q <= ir_q[4:1];
              st_q   <= busy_i ? ST_DONE : ST_RDATA;
            end else if (cnt_q == OP_DEC) begin
              addr_q <= ir_q[5:2];
              st_q   <= ST_DONE;
              if (!busy_i) begin
                unique case (op)
                  OP_WRDIS:  req_q[0] <= 1'b1;
                  OP_STORE:  req_q[1] <= 1'b1;
                  OP_AUTOEN: req_q[2] <= 1'b1;
                  OP_WREN:   req_q[3] <= 1'b1;
                  OP_RECALL: req_q[4] <= 1'b1;
                  OP_WRITE: begin
                    st_q   <= ST_WDATA;
                    kcnt_q <= '0;
                  end
                  default: ;
                endcase
              end
            end
          end
          ST_WDATA: if (sck_rise) begin
            wsr_q <= {wsr_q[DW-2:0], sdi_s};
            if (kcnt_q != KW'(DW)) kcnt_q <= kcnt_q + 1'b1;
          end
          ST_RDATA: begin
            if (sck_rise) begin
              if (cnt_q == OP_DEC) begin
                cnt_q <= RD_FIRST;           // ignored bit 0
              end else if (cnt_q == RD_LAST) begin
                oe_q <= 1'b0;
                st_q <= ST_DONE;
              end else if (oe_q) begin
                rsr_q <= rsr_q << 1;
                cnt_q <= cnt_q + 1'b1;
              end
            end else if (sck_fall && cnt_q == RD_FIRST && !oe_q) begin
              rsr_q <= ram_rdata;
              oe_q  <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sdo_oe_o     = oe_q;
  assign sdo_o        = oe_q & rsr_q[DW-1];
  assign req_wrdis_o  = req_q[0];
  assign req_store_o  = req_q[1];
  assign req_autoen_o = req_q[2];
  assign req_wren_o   = req_q[3];
  assign req_recall_o = req_q[4];
endmodule

// File: rtl/swm_serial_if_chk.sv
module swm_serial_if_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       busy_i,
  input logic       sdo_o,
  input logic       sdo_oe_o,
  input logic [4:0] req_i,
  input logic       ce_s_i,
  input logic       sck_s_i,
  input logic       sck_q_i
);
  AST_REQ_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(req_i)); // R3
  AST_REQ_SINGLE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|req_i) |=> !(|req_i)); // R3
  AST_BUSY_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> !(|req_i)); // R11
  AST_OE_OFF_DESELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_s_i |=> !sdo_oe_o); // R9
  AST_OE_RISE_AFTER_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sdo_oe_o) |-> $past(!sck_s_i && sck_q_i)); // R7
  AST_SDO_ZERO_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sdo_oe_o |-> !sdo_o); // R8
  AST_SDO_MOVES_ON_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sdo_oe_o && $past(sdo_oe_o) && !$stable(sdo_o)) |-> $past(sck_s_i != sck_q_i)); // R12
endmodule

bind swm_serial_if swm_serial_if_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .busy_i  (busy_i),
  .sdo_o   (sdo_o),
  .sdo_oe_o(sdo_oe_o),
  .req_i   ({req_recall_o, req_wren_o, req_autoen_o, req_store_o, req_wrdis_o}),
  .ce_s_i  (ce_s),
  .sck_s_i (sck_s),
  .sck_q_i (sck_q)
);

// File: tb/swm_serial_if_tb_top.sv
module swm_serial_if_tb_top;
  localparam int CLK_P = 10;
  localparam int HALF  = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce = 1'b0, sck = 1'b0, sdi = 1'b0, busy = 1'b0, wr_allow = 1'b1;
  logic sdo, sdo_oe;
  logic [4:0] req;

  always #(CLK_P/2) clk = ~clk;

  swm_serial_if dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ce_i(ce), .sck_i(sck), .sdi_i(sdi),
    .busy_i(busy), .wr_allow_i(wr_allow), .sdo_o(sdo), .sdo_oe_o(sdo_oe),
    .req_wrdis_o(req[0]), .req_store_o(req[1]), .req_autoen_o(req[2]),
    .req_wren_o(req[3]), .req_recall_o(req[4])
  );

  int n_chk = 0, n_err = 0;
  int req_cnt [5];
  logic [15:0] mem_m [16];

  always @(posedge clk)
    for (int i = 0; i < 5; i++) if (req[i] === 1'b1) req_cnt[i]++;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wclk(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic sbit(logic b);
    sdi = b; wclk(2);
    sck = 1'b1; wclk(HALF);
    sck = 1'b0; wclk(HALF);
  endtask

  task automatic ce_on;  ce = 1'b1; wclk(4); endtask
  task automatic ce_off; ce = 1'b0; sdi = 1'b0; wclk(8); endtask

  task automatic instr(logic [3:0] a, logic [2:0] op);
    sbit(1'b1);
    for (int i = 3; i >= 0; i--) sbit(a[i]);
    for (int i = 2; i >= 0; i--) sbit(op[i]);
  endtask

  // write n bits of d (MSB first), optional leading zeros and mid-word pause
  task automatic do_write(logic [3:0] a, logic [31:0] d, int n, int lead, int pause_at);
    int k;
    ce_on;
    for (int i = 0; i < lead; i++) sbit(1'b0);
    instr(a, 3'b011);
    for (int i = n - 1; i >= 0; i--) begin
      if (n - 1 - i == pause_at) wclk(300);
      sbit(d[i]);
    end
    ce_off;
    k = (n > 16) ? 16 : n;
    if (wr_allow && !busy)
      for (int j = 0; j < k; j++) mem_m[a][15-j] = d[k-1-j];
  endtask

  task automatic do_read(logic [3:0] a, logic b0, string tag);
    ce_on;
    sbit(1'b1);
    for (int i = 3; i >= 0; i--) sbit(a[i]);
    sbit(1'b1); sbit(1'b1);
    chk({tag, " R8 hi-z before data"}, {31'd0, sdo_oe}, 32'd0);
    sbit(b0);
    for (int i = 0; i < 16; i++) begin
      if (busy) chk({tag, " R11 no output"}, {30'd0, sdo_oe, sdo}, 32'd0);
      else chk({tag, " R7 bit"}, {30'd0, sdo_oe, sdo}, {30'd0, 1'b1, mem_m[a][15-i]});
      sbit(1'b0);
    end
    chk({tag, " R7 oe off after 24th"}, {31'd0, sdo_oe}, 32'd0);
    ce_off;
  endtask

  task automatic do_req(logic [2:0] op, int idx, string tag);
    int snap [5];
    for (int i = 0; i < 5; i++) snap[i] = req_cnt[i];
    ce_on;
    instr(4'hA, op);
    wclk(4);
    ce_off;
    for (int i = 0; i < 5; i++)
      chk(tag, req_cnt[i] - snap[i], (i == idx && !busy) ? 1 : 0);
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    report;
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mem_m[i] = '0;
    for (int i = 0; i < 5; i++) req_cnt[i] = 0;
    wclk(3);
    rst_n = 1'b1;
    wclk(3);
    chk("R8 reset oe", {31'd0, sdo_oe}, 32'd0);
    chk("R3 reset req", {27'd0, req}, 32'd0);

    // R4 full writes and R2 address decode
    do_write(4'h3, 32'hA5C3, 16, 0, -1);
    do_write(4'hC, 32'h1E7B, 16, 0, -1);
    do_read(4'h3, 1'b0, "R4 R2 word3");
    do_read(4'hC, 1'b1, "R4 R2 wordC");
    do_read(4'h0, 1'b0, "R2 untouched word0");

    // R1 leading zeros
    do_write(4'h5, 32'hBEEF, 16, 5, -1);
    do_read(4'h5, 1'b1, "R1 leading zeros");

    // R5 partial writes
    do_write(4'h3, 32'h0015, 5, 0, -1);
    do_read(4'h3, 1'b0, "R5 five bits");
    do_write(4'hC, 32'h0, 0, 0, -1);
    do_read(4'hC, 1'b0, "R5 zero bits");

    // R6 over-long write
    do_write(4'h7, 32'h000F_1234, 20, 0, -1);
    do_read(4'h7, 1'b0, "R6 twenty bits");

    // R7 ignored bit 0 both ways
    do_read(4'h7, 1'b1, "R7 bit0 one");

    // R3 request opcodes
    do_req(3'b000, 0, "R3 wrdis");
    do_req(3'b001, 1, "R3 store");
    do_req(3'b010, 2, "R3 autoen");
    do_req(3'b100, 3, "R3 wren");
    do_req(3'b101, 4, "R3 recall");

    // R10 write permission
    wr_allow = 1'b0;
    do_write(4'h5, 32'h0000, 16, 0, -1);
    wr_allow = 1'b1;
    do_read(4'h5, 1'b0, "R10 denied write");

    // R11 busy
    busy = 1'b1;
    do_req(3'b001, 1, "R11 store while busy");
    do_write(4'h3, 32'hFFFF, 16, 0, -1);
    do_read(4'h3, 1'b0, "R11 read while busy");
    busy = 1'b0;
    do_read(4'h3, 1'b0, "R11 write while busy");

    // R12 static clock
    do_write(4'h9, 32'h6D29, 16, 0, 8);
    do_read(4'h9, 1'b0, "R12 paused clock");

    // R9 abort mid-instruction and mid-read
    ce_on; sbit(1'b1); sbit(1'b0); sbit(1'b1); ce_off;
    do_write(4'h2, 32'h4C4C, 16, 0, -1);
    do_read(4'h2, 1'b0, "R9 after abort");
    ce_on;
    instr(4'h2, 3'b110);
    sbit(1'b0); sbit(1'b0);
    chk("R9 oe during read", {31'd0, sdo_oe}, 32'd1);
    ce_off;
    chk("R9 oe after abort", {31'd0, sdo_oe}, 32'd0);
    do_req(3'b100, 3, "R9 command after aborted read");

    report;
    $finish;
  end
endmodule